// File: doc/BRIEF.md
# Full-Duplex PCM Serial Transceiver

This block moves 16-bit stereo audio between a parallel word interface and a single-wire serial PCM link in both directions at once. Words written to a 32-entry transmit queue are shifted out MSB first, left channel then right channel. Bits arriving on the serial input are put back together into 16-bit words and queued for reading. A clock generator outside the block supplies a one-cycle bit strobe for each bit period and a frame sync pulse. The frame sync arrives together with the strobe that opens a frame.

A small write-only register port selects the mode. It sets a global run enable, separate queue enables and DMA request enables for each direction, a 6-bit DMA threshold for each direction, and whether each direction's MSB sits in the sync slot or one slot later. The block reports fill counts and four fill flags per queue, two DMA request levels, a latched status vector with a combined pending bit, and an interrupt line.

Top module: `pcm_xcvr`

## Requirements
- R1: After a synchronous reset both counts are 0. Both flag vectors read 4'b0011. `ser_out`, `irq`, `tx_dreq`, `rx_dreq` and `rx_rdata[16]` are 0.
- R2: Each flag vector is {almost full, full, almost empty, empty} in bits [3:0]. Empty means count = 0, almost empty means count <= 4, full means count = 32, and almost full means count >= 28.
- R3: A write (`tx_wr`) enters the transmit queue only if `tx_wdata[16]` is 1, the transmit queue enable (control bit 1) is set, and the queue is not full. A valid write to a full queue is dropped and latches status bit 5.
- R4: `rx_rdata` is {non-empty, oldest word}. A read (`rx_rd`) on an empty queue changes nothing and latches status bit 10.
- R5: A strobe that comes with `fsync` starts slot 0, and every later strobe advances the slot by one. With the transmit MSB-late bit (control bit 3) clear, the left word fills slots 0..15 and the right word fills slots 16..31. With it set, both shift one slot later. Every other slot drives 0. `ser_out` takes the value for a slot in the cycle after that slot's strobe.
- R6: If a word is due while the transmit queue is empty, zeros are sent for that whole word and status bit 4 is latched.
- R7: The bit for slot k is sampled at the strobe that ends slot k. The receive slot placement follows R5, using control bit 4 as the MSB-late bit. Words are assembled MSB first and queued left then right.
- R8: A received word that finds the receive queue full is dropped and latches status bit 11. The count stays at 32.
- R9: `tx_dreq` = global enable (bit 0) & transmit queue enable & transmit DMA enable (bit 5) & (count <= threshold in bits [13:8]). `rx_dreq` = global enable & receive queue enable (bit 2) & receive DMA enable (bit 6) & (count >= threshold in bits [21:16]).
- R10: Status bits [11:0] latch their sources: transmit flags at bits [3:0], receive flags at bits [9:6], and events at bits 4, 5, 10 and 11. Writing 1s to address 2 clears those bits, but a source that is still active sets its bit again. Address 1 holds the source enables in bits [11:0] and the master enable in bit 12. `irq_status[12]` is the OR of enabled status bits, and `irq` is that OR gated by the master enable.
- R11: While the global enable is clear, the serializer drives 0 and neither queue is touched from the serial side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_stb | input | 1 | One-cycle strobe per bit period |
| fsync | input | 1 | Frame sync, valid together with bit_stb |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | 0 control, 1 interrupt enables, 2 status clear |
| cfg_wdata | input | 32 | Register write data |
| tx_wr | input | 1 | Transmit word write |
| tx_wdata | input | 17 | Bit 16 valid, bits [15:0] sample |
| rx_rd | input | 1 | Receive word read (pop) |
| rx_rdata | output | 17 | Bit 16 valid, bits [15:0] oldest sample |
| ser_in | input | 1 | Serial receive data |
| ser_out | output | 1 | Serial transmit data |
| tx_count | output | 6 | Transmit queue fill |
| tx_flags | output | 4 | Transmit fill flags |
| rx_count | output | 6 | Receive queue fill |
| rx_flags | output | 4 | Receive fill flags |
| tx_dreq | output | 1 | Transmit DMA request |
| rx_dreq | output | 1 | Receive DMA request |
| irq_status | output | 13 | Pending bit 12, latched sources [11:0] |
| irq | output | 1 | Interrupt |

## Verification
A wrong slot count or MSB offset shows on `ser_out` within one frame, as a sample shifted by one bit position. On receive it shows as a wrong word at `rx_rdata` on the first read after that frame. A queue pointer or count error shows in the flag vector on the next push or pop, and shows as words read back out of order. Since status bits latch, a missed or spurious underrun or overflow is visible in `irq_status` from the cycle after the event until it is cleared.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
    localparam int SAMPLE_W   = 16;
    localparam int CHANNELS   = 2;
    localparam int FRAME_BITS = SAMPLE_W * CHANNELS;
    localparam int FIFO_DEPTH = 32;
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1);
    localparam int LOW_MARK   = 4;
    localparam int HIGH_MARK  = FIFO_DEPTH - 4;
    localparam int SLOT_W     = 9;
    localparam int POS_W      = $clog2(FRAME_BITS);
    localparam int NSRC       = 12;
    localparam logic [SLOT_W-1:0] FRAME_SLOTS = SLOT_W'(FRAME_BITS);

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_IRQEN = 2'd1,
        REG_CLEAR = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic [CNT_W-1:0] rx_thr;
        logic [CNT_W-1:0] tx_thr;
        logic             rx_dma;
        logic             tx_dma;
        logic             rx_late;
        logic             tx_late;
        logic             rx_fifo;
        logic             tx_fifo;
        logic             enable;
    } ctrl_t;

    typedef struct packed {
        logic afull;
        logic full;
        logic aempty;
        logic empty;
    } fifo_flags_t;

    typedef struct packed {
        logic             hit;
        logic [POS_W-1:0] pos;
    } win_t;

    function automatic ctrl_t decode_ctrl(logic [31:0] d);
        ctrl_t c;
        c.enable  = d[0];
        c.tx_fifo = d[1];
        c.rx_fifo = d[2];
        c.tx_late = d[3];
        c.rx_late = d[4];
        c.tx_dma  = d[5];
        c.rx_dma  = d[6];
        c.tx_thr  = d[8 +: CNT_W];
        c.rx_thr  = d[16 +: CNT_W];
        return c;
    endfunction

    // Maps a frame slot to a data bit position, given the MSB offset.
    function automatic win_t slot_window(logic [SLOT_W-1:0] slot, logic late);
        win_t w;
        logic [SLOT_W-1:0] start;
        logic [SLOT_W-1:0] rel;
        start = {{(SLOT_W-1){1'b0}}, late};
        rel   = slot - start;
        w.hit = (slot >= start) && (rel < FRAME_SLOTS);
        w.pos = rel[POS_W-1:0];
        return w;
    endfunction
endpackage

// File: rtl/pcm_fifo.sv
module pcm_fifo
    import pcm_pkg::*;
#(
    parameter int DW    = SAMPLE_W,
    parameter int DEPTH = FIFO_DEPTH,
    parameter int CW    = $clog2(DEPTH + 1),
    parameter int LOW   = LOW_MARK,
    parameter int HIGH  = HIGH_MARK
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output fifo_flags_t   flags
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
    localparam logic [CW-1:0] LOW_C  = CW'(LOW);
    localparam logic [CW-1:0] HIGH_C = CW'(HIGH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic do_push, do_pop;

    assign do_push = push && (count != FULL_C);
    assign do_pop  = pop && (count != '0);
    assign head    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: ;
            endcase
        end
    end

    always_comb begin
        flags.empty  = (count == '0);
        flags.aempty = (count <= LOW_C);
        flags.full   = (count == FULL_C);
        flags.afull  = (count >= HIGH_C);
    end

    p_count_bound_r2: assert property (@(posedge clk) disable iff (rst)
        count <= FULL_C);
    p_full_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (flags.full && push && !pop) |=> (count == FULL_C));
    p_empty_pop_r4: assert property (@(posedge clk) disable iff (rst)
        (flags.empty && pop && !push) |=> flags.empty);
endmodule

// File: rtl/pcm_ser.sv
module pcm_ser
    import pcm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                stb,
    input  logic                fsync,
    input  logic                framed,
    input  logic [SLOT_W-1:0]   slot_q,
    input  logic                late,
    input  logic                run,
    input  logic [SAMPLE_W-1:0] head,
    input  logic                fifo_empty,
    output logic                pop,
    output logic                starve,
    output logic                ser_out
);
    logic [SLOT_W-1:0]   nslot;
    logic [SAMPLE_W-1:0] sh;
    win_t                w;
    logic                active, load;

    assign nslot  = fsync ? '0 : ((slot_q == '1) ? slot_q : slot_q + 1'b1);
    assign w      = slot_window(nslot, late);
    assign active = stb && run && (framed || fsync) && w.hit;
    assign load   = active && ((w.pos == '0) || (w.pos == POS_W'(SAMPLE_W)));
    assign pop    = load && !fifo_empty;
    assign starve = load && fifo_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh      <= '0;
            ser_out <= 1'b0;
        end else if (stb) begin
            if (!active) begin
                ser_out <= 1'b0;
            end else if (load) begin
                ser_out <= fifo_empty ? 1'b0 : head[SAMPLE_W-1];
                sh      <= fifo_empty ? '0 : {head[SAMPLE_W-2:0], 1'b0};
            end else begin
                ser_out <= sh[SAMPLE_W-1];
                sh      <= {sh[SAMPLE_W-2:0], 1'b0};
            end
        end
    end

    p_idle_low_r11: assert property (@(posedge clk) disable iff (rst)
        (stb && !run) |=> !ser_out);
endmodule

// File: rtl/pcm_des.sv
module pcm_des
    import pcm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                stb,
    input  logic                framed,
    input  logic [SLOT_W-1:0]   slot_q,
    input  logic                late,
    input  logic                run,
    input  logic                ser_in,
    output logic                push,
    output logic [SAMPLE_W-1:0] push_data
);
    logic [SAMPLE_W-1:0] sh;
    win_t                w;
    logic                active;

    assign w         = slot_window(slot_q, late);
    assign active    = stb && run && framed && w.hit;
    assign push      = active && ((w.pos == POS_W'(SAMPLE_W - 1)) ||
                                  (w.pos == POS_W'(FRAME_BITS - 1)));
    assign push_data = {sh[SAMPLE_W-2:0], ser_in};

    always_ff @(posedge clk) begin
        if (rst)         sh <= '0;
        else if (active) sh <= {sh[SAMPLE_W-2:0], ser_in};
    end
endmodule

// File: rtl/pcm_xcvr.sv
module pcm_xcvr
    import pcm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bit_stb,
    input  logic                fsync,
    input  logic                cfg_we,
    input  logic [1:0]          cfg_addr,
    input  logic [31:0]         cfg_wdata,
    input  logic                tx_wr,
    input  logic [SAMPLE_W:0]   tx_wdata,
    input  logic                rx_rd,
    output logic [SAMPLE_W:0]   rx_rdata,
    input  logic                ser_in,
    output logic                ser_out,
    output logic [CNT_W-1:0]    tx_count,
    output logic [3:0]          tx_flags,
    output logic [CNT_W-1:0]    rx_count,
    output logic [3:0]          rx_flags,
    output logic                tx_dreq,
    output logic                rx_dreq,
    output logic [NSRC:0]       irq_status,
    output logic                irq
);
    ctrl_t             ctrl;
    logic [NSRC-1:0]   src_en, stat, src, clr;
    logic              master, pend;
    logic [SLOT_W-1:0] slot_q;
    logic              framed;

    fifo_flags_t         txf, rxf;
    logic [SAMPLE_W-1:0] tx_head, rx_head, rx_word;
    logic tx_req, tx_drop, tx_pop, ser_starve;
    logic rx_push, rx_drop, rx_starve;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            src_en <= '0;
            master <= 1'b0;
        end else if (cfg_we) begin
            case (reg_sel_e'(cfg_addr))
                REG_CTRL:  ctrl <= decode_ctrl(cfg_wdata);
                REG_IRQEN: begin
                    src_en <= cfg_wdata[NSRC-1:0];
                    master <= cfg_wdata[NSRC];
                end
                default: ;
            endcase
        end
    end

    // Shared frame slot counter; saturates when no sync arrives.
    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
            framed <= 1'b0;
        end else if (bit_stb) begin
            if (fsync) begin
                slot_q <= '0;
                framed <= 1'b1;
            end else if (slot_q != '1) begin
                slot_q <= slot_q + 1'b1;
            end
        end
    end

    assign tx_req  = tx_wr && tx_wdata[SAMPLE_W] && ctrl.tx_fifo;
    assign tx_drop = tx_req && txf.full;

    pcm_fifo u_txq (
        .clk(clk), .rst(rst), .push(tx_req), .push_data(tx_wdata[SAMPLE_W-1:0]),
        .pop(tx_pop), .head(tx_head), .count(tx_count), .flags(txf)
    );

    pcm_ser u_ser (
        .clk(clk), .rst(rst), .stb(bit_stb), .fsync(fsync), .framed(framed),
        .slot_q(slot_q), .late(ctrl.tx_late), .run(ctrl.enable && ctrl.tx_fifo),
        .head(tx_head), .fifo_empty(txf.empty), .pop(tx_pop),
        .starve(ser_starve), .ser_out(ser_out)
    );

    pcm_des u_des (
        .clk(clk), .rst(rst), .stb(bit_stb), .framed(framed), .slot_q(slot_q),
        .late(ctrl.rx_late), .run(ctrl.enable && ctrl.rx_fifo), .ser_in(ser_in),
        .push(rx_push), .push_data(rx_word)
    );

    assign rx_drop   = rx_push && rxf.full;
    assign rx_starve = rx_rd && rxf.empty;

    pcm_fifo u_rxq (
        .clk(clk), .rst(rst), .push(rx_push), .push_data(rx_word),
        .pop(rx_rd), .head(rx_head), .count(rx_count), .flags(rxf)
    );

    assign rx_rdata = {!rxf.empty, rx_head};
    assign tx_flags = txf;
    assign rx_flags = rxf;

    assign tx_dreq = ctrl.enable && ctrl.tx_fifo && ctrl.tx_dma && (tx_count <= ctrl.tx_thr);
    assign rx_dreq = ctrl.enable && ctrl.rx_fifo && ctrl.rx_dma && (rx_count >= ctrl.rx_thr);

    assign src = {rx_drop, rx_starve, rxf.afull, rxf.full, rxf.aempty, rxf.empty,
                  tx_drop, ser_starve, txf.afull, txf.full, txf.aempty, txf.empty};
    assign clr = (cfg_we && reg_sel_e'(cfg_addr) == REG_CLEAR) ? cfg_wdata[NSRC-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) stat <= '0;
        else     stat <= (stat & ~clr) | src;
    end

    assign pend       = |(stat & src_en);
    assign irq_status = {pend, stat};
    assign irq        = master && pend;

    p_tx_starve_r6: assert property (@(posedge clk) disable iff (rst)
        ser_starve |=> irq_status[4]);
    p_rx_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        rx_drop |=> (irq_status[11] && rx_count == CNT_W'(FIFO_DEPTH)));
endmodule

// File: tb/tb_pcm_xcvr.sv
module tb_pcm_xcvr;
    localparam int FR  = 40;
    localparam int GAP = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_stb = 1'b0, fsync = 1'b0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic tx_wr = 1'b0;
    logic [16:0] tx_wdata = '0;
    logic rx_rd = 1'b0;
    logic [16:0] rx_rdata;
    logic ser_in = 1'b0, ser_out;
    logic [5:0] tx_count, rx_count;
    logic [3:0] tx_flags, rx_flags;
    logic tx_dreq, rx_dreq, irq;
    logic [12:0] irq_status;

    int total = 0, failed = 0;

    always #5 clk = ~clk;

    pcm_xcvr dut (
        .clk(clk), .rst(rst), .bit_stb(bit_stb), .fsync(fsync),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .tx_wr(tx_wr), .tx_wdata(tx_wdata), .rx_rd(rx_rd), .rx_rdata(rx_rdata),
        .ser_in(ser_in), .ser_out(ser_out), .tx_count(tx_count), .tx_flags(tx_flags),
        .rx_count(rx_count), .rx_flags(rx_flags), .tx_dreq(tx_dreq), .rx_dreq(rx_dreq),
        .irq_status(irq_status), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] smp(int i);
        return 16'(i * 2877 + 23063);
    endfunction

    function automatic logic [FR-1:0] frame_bits(logic [15:0] l, logic [15:0] r, bit late);
        logic [FR-1:0] v = '0;
        for (int i = 0; i < 16; i++) begin
            v[int'(late) + i]      = l[15 - i];
            v[int'(late) + 16 + i] = r[15 - i];
        end
        return v;
    endfunction

    task automatic cfg(input logic [1:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic push(input logic [16:0] d);
        tx_wr = 1'b1; tx_wdata = d;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic pop_check(input logic [16:0] exp, input string req);
        chk(rx_rdata == exp, req, 64'(rx_rdata), 64'(exp));
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
    endtask

    task automatic run_frame(input logic [FR-1:0] rxb, output logic [FR-1:0] txb);
        txb = '0;
        for (int s = 0; s < FR; s++) begin
            bit_stb = 1'b1; fsync = (s == 0);
            @(negedge clk);
            bit_stb = 1'b0; fsync = 1'b0;
            txb[s] = ser_out;
            ser_in = rxb[s];
            repeat (GAP - 1) @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk(tx_count == 0 && rx_count == 0, "R1 counts", 64'({tx_count, rx_count}), 64'(0));
        chk(tx_flags == 4'b0011 && rx_flags == 4'b0011, "R1 flags", 64'({tx_flags, rx_flags}), 64'h33);
        chk(!ser_out && !irq && !tx_dreq && !rx_dreq && !rx_rdata[16], "R1 outputs",
            64'({ser_out, irq, tx_dreq, rx_dreq, rx_rdata[16]}), 64'(0));
    endtask

    task automatic t_tx_fill();
        // enable, tx fifo, tx dma, tx threshold 4
        cfg(2'd0, 32'h1 | 32'h2 | 32'h20 | (32'd4 << 8));
        push({1'b0, 16'hFFFF});
        chk(tx_count == 0, "R3 invalid write ignored", 64'(tx_count), 64'(0));
        for (int i = 0; i < 32; i++) begin
            push({1'b1, smp(i)});
            if (i == 3) begin
                chk(tx_flags == 4'b0010, "R2 count4", 64'(tx_flags), 64'h2);
                chk(tx_dreq == 1'b1, "R9 tx dreq at threshold", 64'(tx_dreq), 64'(1));
            end
            if (i == 4) begin
                chk(tx_flags == 4'b0000, "R2 count5", 64'(tx_flags), 64'h0);
                chk(tx_dreq == 1'b0, "R9 tx dreq above threshold", 64'(tx_dreq), 64'(0));
            end
            if (i == 26) chk(tx_flags == 4'b0000, "R2 count27", 64'(tx_flags), 64'h0);
            if (i == 27) chk(tx_flags == 4'b1000, "R2 count28", 64'(tx_flags), 64'h8);
        end
        chk(tx_count == 32 && tx_flags == 4'b1100, "R2 full", 64'({tx_count, tx_flags}), 64'({6'd32, 4'b1100}));
        chk(irq_status[5] == 1'b0, "R3 no overflow yet", 64'(irq_status), 64'(0));
        push({1'b1, 16'hDEAD});
        chk(tx_count == 32 && irq_status[5], "R3 overflow drop", 64'({tx_count, irq_status[5]}), 64'({6'd32, 1'b1}));
    endtask

    task automatic t_irq();
        cfg(2'd1, 32'h20 | 32'h1000);
        chk(irq && irq_status[12], "R10 irq raised", 64'({irq, irq_status[12]}), 64'h3);
        cfg(2'd2, 32'h20);
        chk(!irq_status[5] && !irq && !irq_status[12], "R10 cleared", 64'(irq_status), 64'(0));
        cfg(2'd2, 32'h4);
        chk(irq_status[2], "R10 active source relatches", 64'(irq_status[2]), 64'(1));
        cfg(2'd1, 32'h20);
        cfg(2'd2, 32'h20);
        push({1'b1, 16'hBEEF});
        chk(irq_status[12] && !irq, "R10 master gate", 64'({irq_status[12], irq}), 64'h2);
        cfg(2'd1, 32'h0);
    endtask

    task automatic t_disabled();
        logic [FR-1:0] txb;
        cfg(2'd0, 32'h2);
        run_frame('0, txb);
        chk(txb == '0 && tx_count == 32, "R11 disabled idle", 64'({txb, tx_count}), 64'({40'h0, 6'd32}));
    endtask

    task automatic t_tx_frames();
        logic [FR-1:0] txb;
        for (int f = 0; f < 16; f++) begin
            bit late = (f >= 8);
            cfg(2'd0, 32'h1 | 32'h2 | (late ? 32'h8 : 32'h0));
            run_frame('0, txb);
            chk(txb == frame_bits(smp(2 * f), smp(2 * f + 1), late), "R5 tx frame",
                64'(txb), 64'(frame_bits(smp(2 * f), smp(2 * f + 1), late)));
        end
        chk(tx_count == 0, "R5 queue drained", 64'(tx_count), 64'(0));
    endtask

    task automatic t_underrun();
        logic [FR-1:0] txb;
        cfg(2'd2, 32'h10);
        run_frame('0, txb);
        chk(txb == '0 && irq_status[4], "R6 underrun zeros", 64'({txb, irq_status[4]}), 64'({40'h0, 1'b1}));
    endtask

    task automatic t_rx();
        logic [FR-1:0] txb;
        // enable, rx fifo, rx dma, rx threshold 32
        cfg(2'd0, 32'h1 | 32'h4 | 32'h40 | (32'd32 << 16));
        run_frame(frame_bits(16'hBEEF, 16'h1357, 1'b0), txb);
        chk(rx_count == 2 && !rx_dreq, "R7 two words, R9 below threshold", 64'({rx_count, rx_dreq}), 64'({6'd2, 1'b0}));
        pop_check({1'b1, 16'hBEEF}, "R7 left early");
        pop_check({1'b1, 16'h1357}, "R7 right early");
        cfg(2'd0, 32'h1 | 32'h4 | 32'h10 | 32'h40 | (32'd32 << 16));
        run_frame(frame_bits(16'h4C2A, 16'hF0F1, 1'b1), txb);
        pop_check({1'b1, 16'h4C2A}, "R7 left late");
        pop_check({1'b1, 16'hF0F1}, "R7 right late");
    endtask

    task automatic t_rx_overflow();
        logic [FR-1:0] txb;
        cfg(2'd0, 32'h1 | 32'h4 | 32'h40 | (32'd32 << 16));
        for (int f = 0; f < 16; f++)
            run_frame(frame_bits(smp(100 + 2 * f), smp(101 + 2 * f), 1'b0), txb);
        chk(rx_count == 32 && rx_flags == 4'b1100 && rx_dreq, "R9 rx dreq full, R2 rx flags",
            64'({rx_count, rx_flags, rx_dreq}), 64'({6'd32, 4'b1100, 1'b1}));
        chk(!irq_status[11], "R8 no overflow yet", 64'(irq_status[11]), 64'(0));
        run_frame(frame_bits(16'h0F0F, 16'h7777, 1'b0), txb);
        chk(rx_count == 32 && irq_status[11], "R8 overflow drop", 64'({rx_count, irq_status[11]}), 64'({6'd32, 1'b1}));
        for (int i = 0; i < 32; i++) pop_check({1'b1, smp(100 + i)}, "R4 R8 order kept");
        chk(irq_status[10] == 1'b0, "R4 no starve yet", 64'(irq_status[10]), 64'(0));
        chk(rx_rdata[16] == 1'b0, "R4 empty invalid", 64'(rx_rdata), 64'(0));
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
        chk(irq_status[10] && rx_count == 0, "R4 read when empty", 64'({irq_status[10], rx_count}), 64'({1'b1, 6'd0}));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_tx_fill();
        t_irq();
        t_disabled();
        // one extra word pushed during t_irq; drain it in the first frame check
        // by pushing nothing further: the queue holds 32 words (33rd was dropped)
        t_tx_frames();
        t_underrun();
        t_rx();
        t_rx_overflow();
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        failed++;
        $display("FAIL watchdog (R1..R11 run) actual=timeout expected=completion");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule